// File: doc/BRIEF.md
# Programmable Periodic Tick Timer

This block produces a periodic interrupt from a slow reference. The 32768 Hz reference arrives as a one-cycle enable pulse in the system clock domain. A free-running divider scales that pulse down by a power of two, and the division is picked by a 4-bit rate field in the control register. On each scaled pulse a down-counter steps once. When the counter expires, it sets a pending flag, raises a level interrupt and reloads itself, so the interrupt period is the reload value times the scaled pulse period.

Software drives the block through a plain strobe interface: one write strobe, a 2-bit word address, write data, and read data that follows the address combinationally. There are four registers: control, reload value, live count (read-only) and interrupt pending (write one to clear). A reload value of 2 or less is refused. The counter starts only when tick enable goes from 0 to 1 while the global enable is set.

Top module: `tick_timer`

## Requirements
- R1: Address 0 is control. Bit 0 is global enable, bits [7:4] are the rate select, bit 8 is tick enable, and every other bit reads 0. A read returns the value last written to these fields.
- R2: The counter steps once for each scaled pulse. A scaled pulse is a reference pulse that arrives while the low N bits of the free-running reference divider are all ones, where N is the rate select. The divider starts at 0 after reset and advances on every reference pulse.
- R3: Address 1 holds the reload value in CNT_W bits. A write whose low CNT_W bits are not greater than 2 leaves the reload value unchanged.
- R4: A control write that sets bit 8 while it was 0, with bit 0 set in the same write and a nonzero reload value, loads the counter with the reload value and starts it. No other control write starts or reloads the counter.
- R5: When a step arrives with the running count at 1, the count reloads, pending bit 0 sets and tick_irq goes high on the same clock edge.
- R6: A control write with bit 0 or bit 8 clear stops the counter, and the count then holds its value across reference pulses.
- R7: At address 3, bit 0 is pending. Writing 1 to bit 0 clears it and drops tick_irq. Writing 0 changes nothing. If an expiry falls in the same cycle as the clear, the expiry wins.
- R8: Address 2 returns the live counter value. Writes to it are ignored.
- R9: After reset all four registers read 0, tick_irq is low and the counter is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_pulse | input | 1 | One-cycle enable at the 32768 Hz reference rate |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Word address: 0 control, 1 reload, 2 count, 3 pending |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for addr, combinational |
| tick_irq | output | 1 | Level tick interrupt, equal to pending bit 0 |

## Verification
The bench builds the block with its default parameters: a 32-bit data path, a 16-bit counter, a 16-bit divider and a reject threshold of 2. With these values a period of only three or five steps is enough to show expiry, reload and wrap at the boundary. The bench issues every reference pulse itself, so it knows the divider phase exactly. That lets it check the rate selects 0, 1 and 2 pulse by pulse, including the case where a scaled pulse lands partway through the divider cycle after a restart.

// File: rtl/tick_pkg.sv
package tick_pkg;

  localparam int SEL_W        = 4;
  localparam int CTRL_GLOB    = 0;
  localparam int CTRL_SEL_LSB = 4;
  localparam int CTRL_TICK    = 8;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_RELOAD = 2'd1,
    REG_COUNT  = 2'd2,
    REG_PEND   = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic             tick_en;
    logic [SEL_W-1:0] rate_sel;
    logic             glob_en;
  } ctrl_t;

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int PRE_W = 16,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_pulse,
  input  logic [SEL_W-1:0] rate_sel,
  output logic             step
);

  logic [PRE_W-1:0] div_q;
  logic [PRE_W-1:0] div_d;
  logic [PRE_W-1:0] mask;

  // mask bit i is set when the selected power exceeds i
  for (genvar i = 0; i < PRE_W; i++) begin : g_mask
    assign mask[i] = (32'(rate_sel) > i);
  end

  always_comb begin
    div_d = div_q;
    if (ref_pulse) div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  assign step = ref_pulse && ((div_q & mask) == mask);

endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             start,
  input  logic             ctrl_wr,
  input  logic             keep_run,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt_q,
  output logic             running_q,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_d;
  logic             run_d;
  logic             halt;

  assign halt   = ctrl_wr && !keep_run;
  assign expire = running_q && step && (cnt_q == CNT_W'(1)) && !halt && !start;

  always_comb begin
    cnt_d = cnt_q;
    run_d = running_q;
    if (start) begin
      cnt_d = reload;
      run_d = 1'b1;
    end else if (halt) begin
      run_d = 1'b0;
    end else if (expire) begin
      cnt_d = reload;
    end else if (running_q && step) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      running_q <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      running_q <= run_d;
    end
  end

endmodule

// File: rtl/tick_regs.sv
module tick_regs
  import tick_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 16,
  parameter int MIN_RELOAD = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              expire,
  input  logic [CNT_W-1:0]  cnt_q,
  output ctrl_t             ctrl_q,
  output logic [CNT_W-1:0]  reload_q,
  output logic              pend_q,
  output logic              start,
  output logic              ctrl_wr,
  output logic              keep_run,
  output logic [DATA_W-1:0] rdata
);

  localparam int CTRL_W = CTRL_TICK + 1;

  ctrl_t            ctrl_d;
  logic [CNT_W-1:0] reload_d;
  logic             pend_d;
  logic             reload_wr;
  logic             pend_wr;
  logic [CNT_W-1:0] wr_cnt;
  logic [CTRL_W-1:0] ctrl_view;

  assign ctrl_wr   = wr_en && (addr == REG_CTRL);
  assign reload_wr = wr_en && (addr == REG_RELOAD);
  assign pend_wr   = wr_en && (addr == REG_PEND);
  assign wr_cnt    = wdata[CNT_W-1:0];

  assign keep_run = wdata[CTRL_GLOB] && wdata[CTRL_TICK];
  assign start    = ctrl_wr && wdata[CTRL_TICK] && !ctrl_q.tick_en &&
                    wdata[CTRL_GLOB] && (reload_q != '0);

  always_comb begin
    ctrl_d   = ctrl_q;
    reload_d = reload_q;
    pend_d   = pend_q;
    if (ctrl_wr) begin
      ctrl_d.glob_en  = wdata[CTRL_GLOB];
      ctrl_d.rate_sel = wdata[CTRL_SEL_LSB +: SEL_W];
      ctrl_d.tick_en  = wdata[CTRL_TICK];
    end
    if (reload_wr && (wr_cnt > CNT_W'(MIN_RELOAD))) reload_d = wr_cnt;
    if (pend_wr && wdata[0]) pend_d = 1'b0;
    if (expire) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      reload_q <= '0;
      pend_q   <= 1'b0;
    end else begin
      ctrl_q   <= ctrl_d;
      reload_q <= reload_d;
      pend_q   <= pend_d;
    end
  end

  always_comb begin
    ctrl_view                           = '0;
    ctrl_view[CTRL_GLOB]                = ctrl_q.glob_en;
    ctrl_view[CTRL_SEL_LSB +: SEL_W]    = ctrl_q.rate_sel;
    ctrl_view[CTRL_TICK]                = ctrl_q.tick_en;
    rdata = '0;
    case (addr)
      REG_CTRL:   rdata[CTRL_W-1:0] = ctrl_view;
      REG_RELOAD: rdata[CNT_W-1:0]  = reload_q;
      REG_COUNT:  rdata[CNT_W-1:0]  = cnt_q;
      default:    rdata[0]          = pend_q;
    endcase
  end

endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 16,
  parameter int PRE_W      = 16,
  parameter int MIN_RELOAD = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_pulse,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              tick_irq
);

  logic             rst_meta;
  logic             rst_sync_n;
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pend_q;
  logic             running_q;
  logic             expire;
  logic             step;
  logic             start;
  logic             ctrl_wr;
  logic             keep_run;

  // reset asserts at once, releases after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  tick_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_pre (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .ref_pulse (ref_pulse),
    .rate_sel  (ctrl_q.rate_sel),
    .step      (step)
  );

  tick_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .MIN_RELOAD(MIN_RELOAD)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .expire   (expire),
    .cnt_q    (cnt_q),
    .ctrl_q   (ctrl_q),
    .reload_q (reload_q),
    .pend_q   (pend_q),
    .start    (start),
    .ctrl_wr  (ctrl_wr),
    .keep_run (keep_run),
    .rdata    (rdata)
  );

  tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .step      (step),
    .start     (start),
    .ctrl_wr   (ctrl_wr),
    .keep_run  (keep_run),
    .reload    (reload_q),
    .cnt_q     (cnt_q),
    .running_q (running_q),
    .expire    (expire)
  );

  assign tick_irq = pend_q;

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 16,
  parameter int MIN_RELOAD = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [1:0]        addr,
  input logic [DATA_W-1:0] wdata,
  input logic              tick_irq,
  input logic              expire,
  input logic              running_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  reload_q
);

  a_r3_reject_small: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd1 && wdata[CNT_W-1:0] <= CNT_W'(MIN_RELOAD)) |=> $stable(reload_q));

  a_r4_run_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    running_q |-> (cnt_q != '0));

  a_r5_irq_from_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tick_irq) |-> $past(expire));

  a_r6_stop_on_global: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd0 && !wdata[0]) |=> !running_q);

  a_r7_clear_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd3 && wdata[0] && !expire) |=> !tick_irq);

endmodule

bind tick_timer tick_timer_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W), .MIN_RELOAD(MIN_RELOAD)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .addr      (addr),
  .wdata     (wdata),
  .tick_irq  (tick_irq),
  .expire    (expire),
  .running_q (running_q),
  .cnt_q     (cnt_q),
  .reload_q  (reload_q)
);

// File: tb/tb_tick_timer.sv
module tb_tick_timer;

  localparam int DATA_W = 32;
  localparam int CNT_W  = 16;

  logic              clk;
  logic              rst_n;
  logic              ref_pulse;
  logic              wr_en;
  logic [1:0]        addr;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] rdata;
  logic              tick_irq;

  int checks;
  int errors;

  // requirement-level model
  logic        m_glob, m_tick;
  logic [3:0]  m_sel;
  logic [15:0] m_reload, m_cnt, m_div;
  logic        m_run, m_pend;

  tick_timer dut (
    .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .tick_irq(tick_irq)
  );

  initial begin
    clk = 1'b0;
    forever #4 clk = ~clk;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    addr = a;
    #1;
    check(tag, rdata, exp);
  endtask

  task automatic check_irq(input string tag);
    #1;
    check(tag, {31'b0, tick_irq}, {31'b0, m_pend});
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
    case (a)
      2'd0: begin
        if (d[8] && !m_tick && d[0] && m_reload != 0) begin
          m_run = 1'b1; m_cnt = m_reload;
        end else if (!(d[0] && d[8])) m_run = 1'b0;
        m_glob = d[0]; m_sel = d[7:4]; m_tick = d[8];
      end
      2'd1: if (d[15:0] > 16'd2) m_reload = d[15:0];
      2'd3: if (d[0]) m_pend = 1'b0;
      default: ;
    endcase
  endtask

  task automatic pulse();
    logic [15:0] mask;
    logic        stp;
    @(negedge clk);
    ref_pulse = 1'b1;
    @(negedge clk);
    ref_pulse = 1'b0;
    mask = 16'((32'd1 << m_sel) - 1);
    stp  = ((m_div & mask) == mask);
    m_div = m_div + 1'b1;
    if (m_run && stp) begin
      if (m_cnt == 16'd1) begin
        m_cnt = m_reload; m_pend = 1'b1;
      end else m_cnt = m_cnt - 1'b1;
    end
  endtask

  task automatic t_reset();
    rd(2'd0, 32'h0, "R9 ctrl after reset");
    rd(2'd1, 32'h0, "R9 reload after reset");
    rd(2'd2, 32'h0, "R9 count after reset");
    rd(2'd3, 32'h0, "R9 pending after reset");
    check("R9 irq after reset", {31'b0, tick_irq}, 32'h0);
  endtask

  task automatic t_ctrl_fields();
    wr(2'd0, 32'hFFFF_FE0E);
    rd(2'd0, 32'h0000_0000, "R1 unused bits read zero");
    wr(2'd0, 32'h0000_00F0);
    rd(2'd0, 32'h0000_00F0, "R1 rate field readback");
    wr(2'd0, 32'h0);
  endtask

  task automatic t_reload_limits();
    wr(2'd1, 32'd2);
    rd(2'd1, 32'd0, "R3 value 2 refused");
    wr(2'd1, 32'd5);
    rd(2'd1, 32'd5, "R3 value 5 taken");
    wr(2'd1, 32'h0001_0001);
    rd(2'd1, 32'd5, "R3 low bits 1 refused");
    wr(2'd1, 32'd3);
    rd(2'd1, 32'd3, "R3 value 3 taken");
    wr(2'd2, 32'd77);
    rd(2'd2, 32'd0, "R8 count not writable");
    wr(2'd1, 32'd5);
  endtask

  task automatic t_no_start_without_global();
    wr(2'd0, 32'h100);
    for (int i = 0; i < 3; i++) pulse();
    rd(2'd2, 32'd0, "R4 no start with global clear");
    wr(2'd0, 32'h0);
  endtask

  task automatic t_period();
    wr(2'd0, 32'h101);
    rd(2'd2, {16'b0, m_reload}, "R4 start loads reload");
    for (int i = 0; i < 12; i++) begin
      pulse();
      rd(2'd2, {16'b0, m_cnt}, "R8 live count rate 0");
      check_irq("R5 irq at expiry");
    end
    wr(2'd3, 32'h0);
    check_irq("R7 write zero keeps pending");
    wr(2'd3, 32'h1);
    check_irq("R7 write one clears");
    rd(2'd3, 32'h0, "R7 pending reads zero");
  endtask

  task automatic t_no_rerise();
    pulse();
    wr(2'd0, 32'h101);
    rd(2'd2, {16'b0, m_cnt}, "R4 repeat write does not reload");
  endtask

  task automatic t_stop();
    wr(2'd0, 32'h001);
    for (int i = 0; i < 4; i++) pulse();
    rd(2'd2, {16'b0, m_cnt}, "R6 tick clear holds count");
    wr(2'd0, 32'h101);
    pulse();
    wr(2'd0, 32'h100);
    for (int i = 0; i < 4; i++) pulse();
    rd(2'd2, {16'b0, m_cnt}, "R6 global clear holds count");
    wr(2'd3, 32'h1);
  endtask

  task automatic t_rate(input logic [3:0] sel, input logic [15:0] rl);
    wr(2'd0, 32'h0);
    wr(2'd1, {16'b0, rl});
    wr(2'd0, 32'h101 | ({28'b0, sel} << 4));
    for (int i = 0; i < 14; i++) begin
      pulse();
      rd(2'd2, {16'b0, m_cnt}, "R2 scaled step count");
      check_irq("R2 scaled expiry");
    end
    wr(2'd3, 32'h1);
    check_irq("R7 clear after scaled run");
  endtask

  initial begin
    checks = 0; errors = 0;
    ref_pulse = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    m_glob = 0; m_tick = 0; m_sel = 0; m_reload = 0; m_cnt = 0;
    m_div = 0; m_run = 0; m_pend = 0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_ctrl_fields();
    t_reload_limits();
    t_no_start_without_global();
    t_period();
    t_no_rerise();
    t_stop();
    t_rate(4'd1, 16'd3);
    t_rate(4'd2, 16'd3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule